// File: doc/BRIEF.md
# Shadowed BCD Calendar Clock

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, date, month, two-digit year and century. It advances once for each pulse on a prescaled one-second tick input. Month lengths are applied, and February gets a 29th day when the two-digit year is a multiple of four. When the year wraps from 99 to 00, the century byte is incremented.

The host never touches the live counters directly. It reads and writes a set of byte-wide shadow registers that sit at the top of a small address window. After every tick the shadow copy is refreshed from the counters. A control byte holds two bits that change this:
- A read-hold bit freezes the shadow copy so that the host can read a set of bytes that belong together, while the counters keep running underneath.
- A write bit also freezes the copy. When the write bit is cleared, the host-edited shadow values are copied into the counters.

A stop bit in the seconds byte halts counting. Six further control bits hold a calibration value that is stored only.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, reads return seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00, century 20 and control 00. With the default 4-bit address, the map is:

  | Address | Byte |
  |---|---|
  | 0xF | year |
  | 0xE | month |
  | 0xD | date |
  | 0xC | day of week |
  | 0xB | hours |
  | 0xA | minutes |
  | 0x9 | seconds |
  | 0x8 | control |
  | 0x1 | century |

- R2: Each tick advances seconds in BCD. Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and carry into the day.
- R3: Day of week counts 1 to 7 and wraps from 7 to 1 on every day carry.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R5: In month 02, the date wraps after 29 when the binary value of the two-digit year is divisible by 4, and after 28 otherwise.
- R6: Month wraps 12→01 and increments the year. Year wraps 99→00 and increments the century. Century wraps 99→00.
- R7: While control bit 6 (read hold) is 1, the shadow bytes do not change on ticks, but the counters keep running. Writing control with bit 6 cleared copies the current counters into the shadow.
- R8: While control bit 7 (write) is 1, the shadow is not refreshed. A control write that clears bit 7 loads the shadow values into the counters, and counting continues from them.
- R9: Bit 7 of the seconds byte is a stop bit. It is written and read at that position. While it is 1, ticks do not advance the time.
- R10: With neither hold bit set, the clock bytes behave as ordinary storage. A host write reads back unchanged until the next tick, which replaces every shadow byte with the counter values.
- R11: Control bits 5:0 are stored and read back, and they have no effect on counting.
- R12: Addresses outside the map read as 00, and writes to them change no readable byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data at bus_addr |

## Verification
The hardest states to reach from the ports are the rare calendar boundaries, such as a 29th of February in a leap year or a year-99 New Year's Eve. At one tick per second, these lie years apart. The stimulus reaches them directly through the write-bit load path. It places the clock one second before each boundary, applies one tick, and compares every byte against a calendar model computed in binary. This is done for every month, and for February in all hundred years. A separate run of 121 ticks carries a Dec 31, 23:58 start across midnight, the month, the year and the century.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    localparam int CTRL_WRITE_BIT = 7;
    localparam int CTRL_HOLD_BIT  = 6;
    localparam int CAL_W          = 6;
    localparam int STOP_BIT       = 7;

    localparam cal_time_t CAL_RESET = '{cent: 8'h20, year: 8'h00, mon: 8'h01,
                                        date: 8'h01, dow: 8'h01, hour: 8'h00,
                                        min: 8'h00, sec: 8'h00};

    // one BCD step, low digit carries into high digit
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] year);
        logic [7:0] yb;
        yb = bcd_to_bin(year);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
    import bcd_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      stop_i,
    input  logic      load_i,
    input  cal_time_t load_val_i,
    output cal_time_t cnt_o,
    output logic      adv_o
);

    typedef struct packed {
        cal_time_t t;
        logic      adv;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cal_time_t  nx;
    logic [7:0] last_day;

    always_comb begin
        last_day = month_last_day(st_q.t.mon, st_q.t.year);
        nx = st_q.t;
        if (st_q.t.sec == 8'h59) begin
            nx.sec = 8'h00;
            if (st_q.t.min == 8'h59) begin
                nx.min = 8'h00;
                if (st_q.t.hour == 8'h23) begin
                    nx.hour = 8'h00;
                    nx.dow  = (st_q.t.dow == 8'h07) ? 8'h01 : st_q.t.dow + 8'h01;
                    if (st_q.t.date == last_day) begin
                        nx.date = 8'h01;
                        if (st_q.t.mon == 8'h12) begin
                            nx.mon = 8'h01;
                            if (st_q.t.year == 8'h99) begin
                                nx.year = 8'h00;
                                nx.cent = (st_q.t.cent == 8'h99) ? 8'h00
                                                                 : bcd_inc(st_q.t.cent);
                            end else begin
                                nx.year = bcd_inc(st_q.t.year);
                            end
                        end else begin
                            nx.mon = bcd_inc(st_q.t.mon);
                        end
                    end else begin
                        nx.date = bcd_inc(st_q.t.date);
                    end
                end else begin
                    nx.hour = bcd_inc(st_q.t.hour);
                end
            end else begin
                nx.min = bcd_inc(st_q.t.min);
            end
        end else begin
            nx.sec = bcd_inc(st_q.t.sec);
        end

        st_d     = st_q;
        st_d.adv = 1'b0;
        if (load_i) begin
            st_d.t               = load_val_i;
            st_d.t.sec[STOP_BIT] = 1'b0;
        end else if (tick_i && !stop_i) begin
            st_d.t   = nx;
            st_d.adv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.t   <= CAL_RESET;
            st_q.adv <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.t;
    assign adv_o = st_q.adv;

    logic step_ok;
    assign step_ok = tick_i && !stop_i && !load_i;

    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && cnt_o.sec == 8'h59) |=> (cnt_o.sec == 8'h00));

    a_r3_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && cnt_o.sec == 8'h59 && cnt_o.min == 8'h59 &&
         cnt_o.hour == 8'h23 && cnt_o.dow == 8'h07) |=> (cnt_o.dow == 8'h01));

    a_r6_cent_only_on_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_o.year != 8'h99) |=> $stable(cnt_o.cent));

    a_r9_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !load_i) |=> $stable(cnt_o));

    a_r8_load_takes_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o.hour == $past(load_val_i.hour) &&
                    cnt_o.date == $past(load_val_i.date) &&
                    cnt_o.sec[6:0] == $past(load_val_i.sec[6:0])));

endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  cal_time_t         cnt_i,
    input  logic              adv_i,
    output logic              stop_o,
    output logic              load_o,
    output cal_time_t         load_val_o
);

    localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'((2**ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'((2**ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'((2**ADDR_W) - 3);
    localparam logic [ADDR_W-1:0] A_DOW  = ADDR_W'((2**ADDR_W) - 4);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'((2**ADDR_W) - 5);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'((2**ADDR_W) - 6);
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'((2**ADDR_W) - 7);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'((2**ADDR_W) - 8);
    localparam logic [ADDR_W-1:0] A_CENT = ADDR_W'((2**ADDR_W) - 15);

    typedef struct packed {
        cal_time_t  sh;
        logic [7:0] ctrl;
        logic       stop;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic hold, ctrl_wr, hold_release, mapped;

    always_comb begin
        hold         = r_q.ctrl[CTRL_WRITE_BIT] | r_q.ctrl[CTRL_HOLD_BIT];
        ctrl_wr      = wr_i && (addr_i == A_CTRL);
        hold_release = ctrl_wr && r_q.ctrl[CTRL_HOLD_BIT] && !wdata_i[CTRL_HOLD_BIT];
        load_o       = ctrl_wr && r_q.ctrl[CTRL_WRITE_BIT] && !wdata_i[CTRL_WRITE_BIT];

        r_d = r_q;
        if ((adv_i && !hold) || hold_release) r_d.sh = cnt_i;
        if (wr_i) begin
            case (addr_i)
                A_YEAR: r_d.sh.year = wdata_i;
                A_MON:  r_d.sh.mon  = wdata_i;
                A_DATE: r_d.sh.date = wdata_i;
                A_DOW:  r_d.sh.dow  = wdata_i;
                A_HOUR: r_d.sh.hour = wdata_i;
                A_MIN:  r_d.sh.min  = wdata_i;
                A_SEC: begin
                    r_d.sh.sec = {1'b0, wdata_i[6:0]};
                    r_d.stop   = wdata_i[STOP_BIT];
                end
                A_CTRL: r_d.ctrl    = wdata_i;
                A_CENT: r_d.sh.cent = wdata_i;
                default: ;
            endcase
        end

        mapped = 1'b1;
        case (addr_i)
            A_YEAR:  rdata_o = r_q.sh.year;
            A_MON:   rdata_o = r_q.sh.mon;
            A_DATE:  rdata_o = r_q.sh.date;
            A_DOW:   rdata_o = r_q.sh.dow;
            A_HOUR:  rdata_o = r_q.sh.hour;
            A_MIN:   rdata_o = r_q.sh.min;
            A_SEC:   rdata_o = {r_q.stop, r_q.sh.sec[6:0]};
            A_CTRL:  rdata_o = r_q.ctrl;
            A_CENT:  rdata_o = r_q.sh.cent;
            default: begin
                rdata_o = 8'h00;
                mapped  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sh   <= CAL_RESET;
            r_q.ctrl <= 8'h00;
            r_q.stop <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stop_o     = r_q.stop;
    assign load_val_o = r_q.sh;

    a_r7_hold_freezes_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_i) |=> $stable(r_q.sh));

    a_r10_refresh_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !hold && !wr_i) |=> (r_q.sh == $past(cnt_i)));

    a_r12_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !mapped && !adv_i) |=> $stable(r_q));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);

    cal_time_t cnt, load_val;
    logic      adv, stop, load;

    bcd_cal_counter u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_1hz),
        .stop_i     (stop),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .adv_o      (adv)
    );

    bcd_cal_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wr_i       (bus_wr),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .cnt_i      (cnt),
        .adv_i      (adv),
        .stop_o     (stop),
        .load_o     (load),
        .load_val_o (load_val)
    );

endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int applied = 0;
    int miscompares = 0;
    bit finished = 0;

    int m_cent, m_year, m_mon, m_date, m_dow, m_hour, m_min, m_sec;
    int m_ctrl;
    bit m_stop;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar #(.ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        if (m_stop) return;
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > days_in(m_mon, m_year)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0;
                                m_cent = (m_cent + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic check_byte(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        applied++;
        if (rdata !== exp) begin
            miscompares++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check_byte(4'hF, to_bcd(m_year), tag);
        check_byte(4'hE, to_bcd(m_mon), tag);
        check_byte(4'hD, to_bcd(m_date), tag);
        check_byte(4'hC, to_bcd(m_dow), tag);
        check_byte(4'hB, to_bcd(m_hour), tag);
        check_byte(4'hA, to_bcd(m_min), tag);
        check_byte(4'h9, {m_stop, to_bcd(m_sec)[6:0]}, tag);
        check_byte(4'h8, 8'(m_ctrl), tag);
        check_byte(4'h1, to_bcd(m_cent), tag);
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_tick();
    endtask

    // R8 load path: write bit set, shadow edited, write bit cleared
    task automatic set_time(input int c, input int y, input int mo, input int d,
                            input int w, input int h, input int mi, input int s);
        bus_write(4'h8, 8'h80);
        bus_write(4'h1, to_bcd(c));
        bus_write(4'hF, to_bcd(y));
        bus_write(4'hE, to_bcd(mo));
        bus_write(4'hD, to_bcd(d));
        bus_write(4'hC, to_bcd(w));
        bus_write(4'hB, to_bcd(h));
        bus_write(4'hA, to_bcd(mi));
        bus_write(4'h9, to_bcd(s));
        bus_write(4'h8, 8'h00);
        m_cent = c; m_year = y; m_mon = mo; m_date = d; m_dow = w;
        m_hour = h; m_min = mi; m_sec = s; m_stop = 0; m_ctrl = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        m_cent = 20; m_year = 0; m_mon = 1; m_date = 1; m_dow = 1;
        m_hour = 0; m_min = 0; m_sec = 0; m_ctrl = 0; m_stop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        check_all("R1 reset values");
        do_tick();
        check_all("R2 first tick");

        // R2 R3 R4 R6: Dec 31 99 23:58:00, carry across every field
        set_time(20, 99, 12, 31, 7, 23, 58, 0);
        check_all("R8 loaded values visible");
        for (int i = 0; i < 121; i++) begin
            do_tick();
            check_all("R2 R3 R6 rollover sweep");
        end

        // R4: last day of each month in a non-leap year
        for (int mo = 1; mo <= 12; mo++) begin
            set_time(19, 23, mo, days_in(mo, 23), 3, 23, 59, 59);
            do_tick();
            check_all("R4 month end");
        end

        // R5: February in every two-digit year, from the 28th and the 29th
        for (int y = 0; y < 100; y++) begin
            set_time(20, y, 2, 28, 5, 23, 59, 59);
            do_tick();
            check_all("R5 feb 28");
            if (y % 4 == 0) begin
                set_time(20, y, 2, 29, 5, 23, 59, 59);
                do_tick();
                check_all("R5 feb 29 leap");
            end
        end

        // R6: century wraps 99 -> 00
        set_time(99, 99, 12, 31, 2, 23, 59, 59);
        do_tick();
        check_all("R6 century wrap");

        // R7: read hold
        set_time(20, 24, 6, 15, 4, 10, 20, 10);
        bus_write(4'h8, 8'h40);
        do_tick(); do_tick(); do_tick();
        check_byte(4'h9, 8'h10, "R7 shadow frozen");
        check_byte(4'hA, 8'h20, "R7 shadow frozen");
        bus_write(4'h8, 8'h00);
        check_all("R7 release shows running count");

        // R8: write bit, counters load on clear
        bus_write(4'h8, 8'h80);
        bus_write(4'hB, 8'h05);
        do_tick(); do_tick();
        check_byte(4'h9, to_bcd(m_sec - 2), "R8 shadow not refreshed");
        bus_write(4'h8, 8'h00);
        m_sec = m_sec - 2; m_hour = 5;
        check_all("R8 loaded from shadow");
        do_tick();
        check_all("R8 counts from loaded time");

        // R9: stop bit
        bus_write(4'h9, 8'h80 | to_bcd(m_sec));
        m_stop = 1;
        do_tick(); do_tick(); do_tick();
        check_all("R9 stopped");
        bus_write(4'h9, to_bcd(m_sec));
        m_stop = 0;
        do_tick();
        check_all("R9 restarted");

        // R10: shadow is plain storage until the next tick
        bus_write(4'hA, 8'h33);
        check_byte(4'hA, 8'h33, "R10 write reads back");
        bus_write(4'hD, 8'h07);
        check_byte(4'hD, 8'h07, "R10 write reads back");
        do_tick();
        check_all("R10 tick restores counters");

        // R11: calibration bits stored, no effect on counting
        bus_write(4'h8, 8'h2A);
        m_ctrl = 8'h2A;
        check_byte(4'h8, 8'h2A, "R11 calibration readback");
        do_tick();
        check_all("R11 counting unaffected");
        bus_write(4'h8, 8'h15);
        m_ctrl = 8'h15;
        do_tick();
        check_all("R11 counting unaffected");
        bus_write(4'h8, 8'h00);
        m_ctrl = 0;

        // R12: unmapped addresses
        for (int a = 0; a < 8; a++) begin
            if (a != 1) begin
                bus_write(4'(a), 8'hFF);
                check_byte(4'(a), 8'h00, "R12 unmapped reads zero");
            end
        end
        check_all("R12 mapped bytes untouched");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule